// File: doc/BRIEF.md
# Variable Page Size TLB Lookup

This block is the lookup half of a fully associative translation buffer for a 64-bit memory management unit. It holds a parameterised number of entries (64 by default), and each entry carries its own page size of 8 KB, 64 KB, 512 KB or 4 MB. Every request compares its virtual address against all entries in parallel. The compare mask follows each entry's page size. The context tag is compared unless the entry is global. The lowest-numbered matching entry supplies the translation.

A request carries the access kind (read, write, no-fault load or instruction fetch), a privilege flag, a context selector and a trap-level flag. The block returns a 41-bit physical page address, read/write/execute permissions, a hit or miss indication, and either an access fault or a protection fault. It keeps a tag-access register, a fault status register and a fault address register, and it marks the used bit of every entry that serves a successful lookup. A separate write port loads entries. A physical-bypass request skips translation altogether. Replacement and refill belong to other logic.

Top module: `vpage_xlate`

## Requirements
- R1: When several entries match, the entry with the lowest index supplies the result.
- R2: Page-size code 0, 1, 2 or 3 gives a page of 8 KB, 64 KB, 512 KB or 4 MB. Address bits below the page size are left out of the compare.
- R3: An entry matches only if it is valid, and either it is global or its 13-bit context equals the current context.
- R4: On a hit, `rsp_pa` takes the entry's physical bits above the page size and the request's address bits below it. Bits 12:0 are zero.
- R5: Context selector 0 picks the primary context, 1 picks the secondary context, and 2 or 3 picks context 0. A fetch (kind 3) uses the primary context when `tl_nonzero` is 0 and context 0 otherwise. Kind codes: 0 read, 1 write, 2 no-fault load.
- R6: An access fault is raised by any of three causes, and each sets its own status bit. A user access (`req_priv`=0) to a privileged entry sets bit 7. A no-fault load to a side-effect entry sets bit 8. A read or write to a no-fault-only entry sets bit 9. Several of these bits can be set together, and a fetch checks privilege only.
- R7: A write to a non-writable entry raises `rsp_prot`, but only when no access fault applies.
- R8: Every translated request loads `tag_access` with {va[63:13], context}, whether it hits, misses or faults. A miss raises `rsp_miss`.
- R9: A fault of either kind writes `fsr` and copies the full address into `far`. The `fsr` bits are: 0 valid; 1 overwrite, equal to the old valid bit; 2 the request's `req_priv`; 4:3 the context type (0 primary, 1 secondary, 2 nucleus; a fetch gives 2 when `tl_nonzero` is 1, else 0); 5 write; 6 no-fault load. A miss leaves `fsr` and `far` unchanged.
- R10: A successful data lookup grants read, and grants write only when the entry is writable. A successful fetch grants execute only. Success sets the entry's bit in `used_vec`, and an entry write clears that bit.
- R11: A request with `req_phys`=1 returns hit, the address truncated to 41 bits, and all three permissions. It changes no state.
- R12: Results appear on the cycle after the request, with `rsp_valid` high. An entry write is visible to the next request. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 no-fault load, 3 fetch |
| req_priv | input | 1 | 1 = privileged access |
| req_ctx_sel | input | 2 | 0 primary, 1 secondary, 2/3 nucleus |
| req_phys | input | 1 | Physical bypass |
| tl_nonzero | input | 1 | Trap level above zero (fetch context) |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index |
| wr_va | input | 64 | Entry virtual tag |
| wr_ctx | input | 13 | Entry context |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Entry ignores context |
| wr_size | input | 2 | Page-size code |
| wr_pa | input | 41 | Entry physical address |
| wr_priv | input | 1 | Privileged-only entry |
| wr_writable | input | 1 | Writable entry |
| wr_nfo | input | 1 | No-fault-only entry |
| wr_side | input | 1 | Side-effect entry |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | An entry matched (or bypass) |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Access fault |
| rsp_prot | output | 1 | Protection fault |
| rsp_pa | output | 41 | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |
| tag_access | output | 64 | Tag-access register |
| fsr | output | 10 | Fault status register |
| far | output | 64 | Fault address register |
| used_vec | output | 64 | Per-entry used bits |

## Verification
The bench sets up two entries that both match the same address, and checks that the lower index wins. A design that scanned from the top index would return the wrong physical page. It also sends offsets just inside and just outside each page size; a wrong mask shift shows up as a miss on a large page or a false hit next to a small one. Other stimuli stack several fault causes on one access, including a write to a read-only page that also has a privilege violation. A design that merged the causes would drop a status bit or raise `rsp_prot` where it must stay low. Back-to-back faults followed by a miss expose a missing overwrite bit, and a miss that wrongly touches `fsr` or `far`.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

   typedef enum logic [1:0] {
      ACC_READ   = 2'd0,
      ACC_WRITE  = 2'd1,
      ACC_NFLOAD = 2'd2,
      ACC_FETCH  = 2'd3
   } acc_kind_e;

   localparam logic [1:0] CT_PRIMARY   = 2'd0;
   localparam logic [1:0] CT_SECONDARY = 2'd1;
   localparam logic [1:0] CT_NUCLEUS   = 2'd2;

   // per-entry attribute bits
   typedef struct packed {
      logic       valid;
      logic       global_en;
      logic [1:0] size;
      logic       priv;
      logic       writable;
      logic       nfo;
      logic       side;
   } ent_attr_t;

endpackage

// File: rtl/xlt_store.sv
module xlt_store
   import xlt_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VA_W    = 64,
   parameter int PA_W    = 41,
   parameter int CTX_W   = 13,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VA_W-1:0]  wr_tag,
   input  logic [CTX_W-1:0] wr_ctx,
   input  ent_attr_t        wr_attr,
   input  logic [PA_W-1:0]  wr_pa,
   input  logic             set_used,
   input  logic [IDX_W-1:0] set_idx,
   output logic [VA_W-1:0]  tag_q  [ENTRIES],
   output logic [CTX_W-1:0] ctx_q  [ENTRIES],
   output ent_attr_t        attr_q [ENTRIES],
   output logic [PA_W-1:0]  pa_q   [ENTRIES],
   output logic [ENTRIES-1:0] used_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i]  <= '0;
            ctx_q[i]  <= '0;
            attr_q[i] <= '0;
            pa_q[i]   <= '0;
         end
         used_q <= '0;
      end else begin
         if (set_used && (32'(set_idx) < ENTRIES))
            used_q[set_idx] <= 1'b1;
         // a write in the same cycle overrides the used update
         if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            tag_q[wr_idx]  <= wr_tag;
            ctx_q[wr_idx]  <= wr_ctx;
            attr_q[wr_idx] <= wr_attr;
            pa_q[wr_idx]   <= wr_pa;
            used_q[wr_idx] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/xlt_match.sv
module xlt_match
   import xlt_pkg::*;
#(
   parameter int ENTRIES  = 64,
   parameter int VA_W     = 64,
   parameter int PA_W     = 41,
   parameter int CTX_W    = 13,
   parameter int PG_SHIFT = 13,
   parameter bit LOW_WINS = 1'b1,
   parameter int IDX_W    = $clog2(ENTRIES)
) (
   input  logic [VA_W-1:0]  va,
   input  logic [CTX_W-1:0] ctx,
   input  logic [VA_W-1:0]  tag_q  [ENTRIES],
   input  logic [CTX_W-1:0] ctx_q  [ENTRIES],
   input  ent_attr_t        attr_q [ENTRIES],
   input  logic [PA_W-1:0]  pa_q   [ENTRIES],
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic [PA_W-1:0]  hit_pa,
   output logic             hit_priv,
   output logic             hit_writable,
   output logic             hit_nfo,
   output logic             hit_side
);

   localparam logic [PA_W-1:0] LOW_CLR = {{(PA_W-PG_SHIFT){1'b1}}, {PG_SHIFT{1'b0}}};

   function automatic logic [VA_W-1:0] size_mask(input logic [1:0] sz);
      logic [VA_W-1:0] span;
      span = VA_W'(1) << (PG_SHIFT + 3 * int'(sz));
      return ~(span - VA_W'(1));
   endfunction

   logic [ENTRIES-1:0] hitv;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic [VA_W-1:0] msk;
      logic            ctx_ok;
      assign msk       = size_mask(attr_q[g].size);
      assign ctx_ok    = attr_q[g].global_en || (ctx_q[g] == ctx);
      assign hitv[g]   = attr_q[g].valid && ctx_ok && (((va ^ tag_q[g]) & msk) == '0);
   end

   if (LOW_WINS) begin : g_low_first
      always_comb begin
         hit     = 1'b0;
         hit_idx = '0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hitv[i]) begin
               hit     = 1'b1;
               hit_idx = IDX_W'(i);
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         hit     = 1'b0;
         hit_idx = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (hitv[i]) begin
               hit     = 1'b1;
               hit_idx = IDX_W'(i);
            end
         end
      end
   end

   logic [VA_W-1:0] sel_mask;
   ent_attr_t       sel_attr;

   always_comb begin
      sel_attr     = attr_q[hit_idx];
      sel_mask     = size_mask(sel_attr.size);
      hit_pa       = ((pa_q[hit_idx] & sel_mask[PA_W-1:0]) |
                      (va[PA_W-1:0] & ~sel_mask[PA_W-1:0])) & LOW_CLR;
      hit_priv     = sel_attr.priv;
      hit_writable = sel_attr.writable;
      hit_nfo      = sel_attr.nfo;
      hit_side     = sel_attr.side;
   end

endmodule

// File: rtl/xlt_fault.sv
module xlt_fault
   import xlt_pkg::*;
(
   input  acc_kind_e kind,
   input  logic      user,
   input  logic      e_priv,
   input  logic      e_writable,
   input  logic      e_nfo,
   input  logic      e_side,
   output logic      ft_priv,
   output logic      ft_side,
   output logic      ft_nfo,
   output logic      acc_fault,
   output logic      prot_fault
);

   always_comb begin
      ft_priv    = user && e_priv;
      ft_side    = (kind == ACC_NFLOAD) && e_side;
      ft_nfo     = ((kind == ACC_READ) || (kind == ACC_WRITE)) && e_nfo;
      acc_fault  = ft_priv || ft_side || ft_nfo;
      prot_fault = !acc_fault && (kind == ACC_WRITE) && !e_writable;
   end

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
   import xlt_pkg::*;
#(
   parameter int ENTRIES  = 64,
   parameter int VA_W     = 64,
   parameter int PA_W     = 41,
   parameter int CTX_W    = 13,
   parameter int PG_SHIFT = 13,
   parameter bit LOW_WINS = 1'b1,
   localparam int IDX_W   = $clog2(ENTRIES),
   localparam int FSR_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_va,
   input  logic [1:0]         req_kind,
   input  logic               req_priv,
   input  logic [1:0]         req_ctx_sel,
   input  logic               req_phys,
   input  logic               tl_nonzero,
   input  logic [CTX_W-1:0]   pri_ctx,
   input  logic [CTX_W-1:0]   sec_ctx,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VA_W-1:0]    wr_va,
   input  logic [CTX_W-1:0]   wr_ctx,
   input  logic               wr_valid,
   input  logic               wr_global,
   input  logic [1:0]         wr_size,
   input  logic [PA_W-1:0]    wr_pa,
   input  logic               wr_priv,
   input  logic               wr_writable,
   input  logic               wr_nfo,
   input  logic               wr_side,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic               rsp_miss,
   output logic               rsp_fault,
   output logic               rsp_prot,
   output logic [PA_W-1:0]    rsp_pa,
   output logic               rsp_rd,
   output logic               rsp_wr,
   output logic               rsp_ex,
   output logic [VA_W-1:0]    tag_access,
   output logic [FSR_W-1:0]   fsr,
   output logic [VA_W-1:0]    far,
   output logic [ENTRIES-1:0] used_vec
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (CTX_W != PG_SHIFT) begin : g_bad_ctx
      $error("context width must equal the base page shift");
   end
   if ((PA_W > VA_W) || (PA_W < PG_SHIFT + 10)) begin : g_bad_pa
      $error("PA_W must fit in VA_W and hold a 4 MB page offset");
   end

   acc_kind_e kind;
   assign kind = acc_kind_e'(req_kind);

   // context and context type selection
   logic [CTX_W-1:0] cur_ctx;
   logic [1:0]       cur_ctype;

   always_comb begin
      if (kind == ACC_FETCH) begin
         cur_ctx   = tl_nonzero ? '0 : pri_ctx;
         cur_ctype = tl_nonzero ? CT_NUCLEUS : CT_PRIMARY;
      end else begin
         unique case (req_ctx_sel)
            2'd0:    begin cur_ctx = pri_ctx; cur_ctype = CT_PRIMARY;   end
            2'd1:    begin cur_ctx = sec_ctx; cur_ctype = CT_SECONDARY; end
            default: begin cur_ctx = '0;      cur_ctype = CT_NUCLEUS;   end
         endcase
      end
   end

   // entry storage
   logic [VA_W-1:0]  tag_q  [ENTRIES];
   logic [CTX_W-1:0] ctx_q  [ENTRIES];
   ent_attr_t        attr_q [ENTRIES];
   logic [PA_W-1:0]  pa_q   [ENTRIES];
   ent_attr_t        wr_attr;
   logic             set_used;
   logic             m_hit;
   logic [IDX_W-1:0] m_idx;

   assign wr_attr = '{valid: wr_valid, global_en: wr_global, size: wr_size,
                      priv: wr_priv, writable: wr_writable, nfo: wr_nfo, side: wr_side};

   xlt_store #(
      .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .IDX_W(IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_va),
      .wr_ctx   (wr_ctx),
      .wr_attr  (wr_attr),
      .wr_pa    (wr_pa),
      .set_used (set_used),
      .set_idx  (m_idx),
      .tag_q    (tag_q),
      .ctx_q    (ctx_q),
      .attr_q   (attr_q),
      .pa_q     (pa_q),
      .used_q   (used_vec)
   );

   // parallel compare and first-match select
   logic [PA_W-1:0] m_pa;
   logic            m_priv, m_writable, m_nfo, m_side;

   xlt_match #(
      .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W),
      .PG_SHIFT(PG_SHIFT), .LOW_WINS(LOW_WINS), .IDX_W(IDX_W)
   ) u_match (
      .va           (req_va),
      .ctx          (cur_ctx),
      .tag_q        (tag_q),
      .ctx_q        (ctx_q),
      .attr_q       (attr_q),
      .pa_q         (pa_q),
      .hit          (m_hit),
      .hit_idx      (m_idx),
      .hit_pa       (m_pa),
      .hit_priv     (m_priv),
      .hit_writable (m_writable),
      .hit_nfo      (m_nfo),
      .hit_side     (m_side)
   );

   // fault classification
   logic ft_priv, ft_side, ft_nfo, acc_fault, prot_fault;

   xlt_fault u_fault (
      .kind       (kind),
      .user       (!req_priv),
      .e_priv     (m_priv),
      .e_writable (m_writable),
      .e_nfo      (m_nfo),
      .e_side     (m_side),
      .ft_priv    (ft_priv),
      .ft_side    (ft_side),
      .ft_nfo     (ft_nfo),
      .acc_fault  (acc_fault),
      .prot_fault (prot_fault)
   );

   logic translate, any_fault, success;
   assign translate = req_valid && !req_phys;
   assign any_fault = m_hit && (acc_fault || prot_fault);
   assign success   = m_hit && !acc_fault && !prot_fault;
   assign set_used  = translate && success;

   logic [FSR_W-1:0] fsr_d;
   assign fsr_d = {ft_nfo, ft_side, ft_priv, (kind == ACC_NFLOAD), (kind == ACC_WRITE),
                   cur_ctype, req_priv, fsr[0], 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_miss   <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_prot   <= 1'b0;
         rsp_pa     <= '0;
         rsp_rd     <= 1'b0;
         rsp_wr     <= 1'b0;
         rsp_ex     <= 1'b0;
         tag_access <= '0;
         fsr        <= '0;
         far        <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_prot  <= 1'b0;
         rsp_pa    <= '0;
         rsp_rd    <= 1'b0;
         rsp_wr    <= 1'b0;
         rsp_ex    <= 1'b0;
         if (req_valid && req_phys) begin
            rsp_hit <= 1'b1;
            rsp_pa  <= req_va[PA_W-1:0];
            rsp_rd  <= 1'b1;
            rsp_wr  <= 1'b1;
            rsp_ex  <= 1'b1;
         end else if (translate) begin
            rsp_hit    <= m_hit;
            rsp_miss   <= !m_hit;
            rsp_fault  <= m_hit && acc_fault;
            rsp_prot   <= m_hit && prot_fault;
            rsp_pa     <= m_hit ? m_pa : '0;
            rsp_rd     <= success && (kind != ACC_FETCH);
            rsp_wr     <= success && (kind != ACC_FETCH) && m_writable;
            rsp_ex     <= success && (kind == ACC_FETCH);
            tag_access <= {req_va[VA_W-1:PG_SHIFT], cur_ctx};
            if (any_fault) begin
               fsr <= fsr_d;
               far <= req_va;
            end
         end
      end
   end

endmodule

// File: rtl/vpage_xlate_chk.sv
module vpage_xlate_chk #(
   parameter int PA_W     = 41,
   parameter int VA_W     = 64,
   parameter int PG_SHIFT = 13,
   parameter int FSR_W    = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_phys,
   input logic [PA_W-1:0]  req_va_lo,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             rsp_miss,
   input logic             rsp_fault,
   input logic             rsp_prot,
   input logic [PA_W-1:0]  rsp_pa,
   input logic             rsp_rd,
   input logic             rsp_wr,
   input logic             rsp_ex,
   input logic [FSR_W-1:0] fsr,
   input logic [VA_W-1:0]  far
);

   p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && !rsp_prot));

   p_miss_keeps_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> ($stable(fsr) && $stable(far)));

   p_fault_sets_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_fault || rsp_prot)) |-> fsr[0]);

   p_overwrite_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_fault || rsp_prot) && $past(fsr[0])) |-> fsr[1]);

   p_prot_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_prot |-> (!rsp_fault && rsp_hit));

   p_write_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wr |-> (rsp_rd && !rsp_fault && !rsp_prot));

   p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_phys) |->
         (rsp_hit && rsp_rd && rsp_wr && rsp_ex && (rsp_pa == $past(req_va_lo))));

   p_pa_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_valid && !req_phys) && rsp_hit) |-> (rsp_pa[PG_SHIFT-1:0] == '0));

endmodule

bind vpage_xlate vpage_xlate_chk #(
   .PA_W(PA_W), .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .FSR_W(FSR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_phys  (req_phys),
   .req_va_lo (req_va[PA_W-1:0]),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .rsp_fault (rsp_fault),
   .rsp_prot  (rsp_prot),
   .rsp_pa    (rsp_pa),
   .rsp_rd    (rsp_rd),
   .rsp_wr    (rsp_wr),
   .rsp_ex    (rsp_ex),
   .fsr       (fsr),
   .far       (far)
);

// File: tb/vpage_xlate_tb_top.sv
`timescale 1ns/1ps
module vpage_xlate_tb_top;

   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_va = '0;
   logic [1:0]  req_kind = '0;
   logic        req_priv = 1'b0;
   logic [1:0]  req_ctx_sel = '0;
   logic        req_phys = 1'b0;
   logic        tl_nonzero = 1'b0;
   logic [12:0] pri_ctx = 13'h0055;
   logic [12:0] sec_ctx = 13'h00aa;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [63:0] wr_va = '0;
   logic [12:0] wr_ctx = '0;
   logic        wr_valid = 1'b0, wr_global = 1'b0;
   logic [1:0]  wr_size = '0;
   logic [40:0] wr_pa = '0;
   logic        wr_priv = 1'b0, wr_writable = 1'b0, wr_nfo = 1'b0, wr_side = 1'b0;

   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot, rsp_rd, rsp_wr, rsp_ex;
   logic [40:0] rsp_pa;
   logic [63:0] tag_access, far;
   logic [9:0]  fsr;
   logic [N-1:0] used_vec;

   always #2 clk = ~clk;

   vpage_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_kind(req_kind), .req_priv(req_priv), .req_ctx_sel(req_ctx_sel),
      .req_phys(req_phys), .tl_nonzero(tl_nonzero), .pri_ctx(pri_ctx),
      .sec_ctx(sec_ctx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_va(wr_va),
      .wr_ctx(wr_ctx), .wr_valid(wr_valid), .wr_global(wr_global),
      .wr_size(wr_size), .wr_pa(wr_pa), .wr_priv(wr_priv),
      .wr_writable(wr_writable), .wr_nfo(wr_nfo), .wr_side(wr_side),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_fault(rsp_fault), .rsp_prot(rsp_prot), .rsp_pa(rsp_pa),
      .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
      .tag_access(tag_access), .fsr(fsr), .far(far), .used_vec(used_vec)
   );

   typedef struct packed {
      logic        hit, miss, fault, prot;
      logic [40:0] pa;
      logic        rd, wr, ex;
      logic [63:0] tacc;
      logic [9:0]  fsr;
      logic [63:0] far;
   } item_t;

   item_t exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // shadow of the entry table, kept from the requirements
   logic [63:0] s_tag [N];
   logic [12:0] s_ctx [N];
   logic [40:0] s_pa  [N];
   logic [1:0]  s_size[N];
   logic        s_val [N], s_glb[N], s_prv[N], s_wrt[N], s_nfo[N], s_sde[N];
   logic [63:0] m_tacc = '0, m_far = '0;
   logic [9:0]  m_fsr = '0;
   logic [N-1:0] m_used = '0;

   initial begin
      for (int i = 0; i < N; i++) begin
         s_tag[i] = '0; s_ctx[i] = '0; s_pa[i] = '0; s_size[i] = '0;
         s_val[i] = 0; s_glb[i] = 0; s_prv[i] = 0; s_wrt[i] = 0; s_nfo[i] = 0; s_sde[i] = 0;
      end
   end

   task automatic check(input string t, input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
   endtask

   // monitor: pop one expected item per result
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         item_t act;
         act = '{hit: rsp_hit, miss: rsp_miss, fault: rsp_fault, prot: rsp_prot,
                 pa: rsp_pa, rd: rsp_rd, wr: rsp_wr, ex: rsp_ex,
                 tacc: tag_access, fsr: fsr, far: far};
         if (exp_q.size() == 0) begin
            check("R12 unexpected result", 256'(act), 256'(0) | 256'(1));
         end else begin
            item_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 256'(act), 256'(e));
         end
      end
   end

   task automatic write_entry(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                              input bit val, input bit glb, input logic [1:0] sz,
                              input logic [40:0] pa, input bit prv, input bit wrt,
                              input bit nfo, input bit sde);
      @(negedge clk);
      wr_en = 1; wr_idx = 6'(idx); wr_va = va; wr_ctx = ctx; wr_valid = val;
      wr_global = glb; wr_size = sz; wr_pa = pa; wr_priv = prv; wr_writable = wrt;
      wr_nfo = nfo; wr_side = sde;
      s_tag[idx] = va; s_ctx[idx] = ctx; s_val[idx] = val; s_glb[idx] = glb;
      s_size[idx] = sz; s_pa[idx] = pa; s_prv[idx] = prv; s_wrt[idx] = wrt;
      s_nfo[idx] = nfo; s_sde[idx] = sde; m_used[idx] = 1'b0;
      @(negedge clk);
      wr_en = 0;
   endtask

   // driver: build the expected item from the shadow, push it, drive the request
   task automatic do_req(input string t, input logic [63:0] va, input logic [1:0] kind,
                         input bit priv, input logic [1:0] sel, input bit phys, input bit tl);
      item_t e;
      logic [12:0] ctx;
      logic [1:0]  ctype;
      int          hi;
      e = '0;
      e.tacc = m_tacc; e.fsr = m_fsr; e.far = m_far;
      if (kind == 2'd3) begin ctx = tl ? 13'd0 : pri_ctx; ctype = tl ? 2'd2 : 2'd0; end
      else if (sel == 2'd0) begin ctx = pri_ctx; ctype = 2'd0; end
      else if (sel == 2'd1) begin ctx = sec_ctx; ctype = 2'd1; end
      else begin ctx = 13'd0; ctype = 2'd2; end
      if (phys) begin
         e.hit = 1; e.pa = va[40:0]; e.rd = 1; e.wr = 1; e.ex = 1;
      end else begin
         hi = -1;
         for (int i = 0; i < N; i++) begin
            logic [63:0] pm;
            pm = ~((64'd1 << (13 + 3 * int'(s_size[i]))) - 64'd1);
            if (hi < 0 && s_val[i] && (s_glb[i] || s_ctx[i] == ctx) && (((va ^ s_tag[i]) & pm) == 0))
               hi = i;
         end
         m_tacc = {va[63:13], ctx};
         e.tacc = m_tacc;
         if (hi < 0) begin
            e.miss = 1;
         end else begin
            logic [40:0] pm41;
            bit fp, fs, fn, af, pf;
            pm41 = 41'(~((64'd1 << (13 + 3 * int'(s_size[hi]))) - 64'd1));
            e.hit = 1;
            e.pa = ((s_pa[hi] & pm41) | (va[40:0] & ~pm41)) & ~41'h1fff;
            fp = !priv && s_prv[hi];
            fs = (kind == 2'd2) && s_sde[hi];
            fn = (kind <= 2'd1) && s_nfo[hi];
            af = fp || fs || fn;
            pf = !af && (kind == 2'd1) && !s_wrt[hi];
            e.fault = af; e.prot = pf;
            if (af || pf) begin
               m_fsr = {fn, fs, fp, kind == 2'd2, kind == 2'd1, ctype, priv, m_fsr[0], 1'b1};
               m_far = va;
               e.fsr = m_fsr; e.far = m_far;
            end else begin
               e.rd = (kind != 2'd3);
               e.wr = (kind != 2'd3) && s_wrt[hi];
               e.ex = (kind == 2'd3);
               m_used[hi] = 1'b1;
            end
         end
      end
      @(negedge clk);
      req_valid = 1; req_va = va; req_kind = kind; req_priv = priv;
      req_ctx_sel = sel; req_phys = phys; tl_nonzero = tl;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      req_valid = 0; req_phys = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      check("R12 reset outputs", 256'({rsp_valid, rsp_hit, rsp_miss, fsr, far, tag_access, rsp_pa}), 256'(0));
      check("R12 reset used bits", 256'(used_vec), 256'(0));

      write_entry(2,  64'h0000_1234_5678_A000, 13'h055, 1, 0, 2'd0, 41'h0AB_CDEF_2000, 0, 1, 0, 0);
      write_entry(7,  64'h0000_0000_4003_0000, 13'h055, 1, 0, 2'd1, 41'h00F_0000_0000, 0, 0, 0, 0);
      write_entry(9,  64'h0000_0000_8000_0000, 13'h0aa, 1, 0, 2'd2, 41'h020_0008_0000, 0, 1, 0, 0);
      write_entry(12, 64'hFFFF_F800_0040_0000, 13'h003, 1, 1, 2'd3, 41'h1C0_0000_0000, 1, 1, 0, 0);
      write_entry(3,  64'h0000_0000_0060_0000, 13'h055, 1, 0, 2'd0, 41'h000_1111_0000, 0, 0, 0, 0);
      write_entry(20, 64'h0000_0000_0060_0000, 13'h055, 1, 0, 2'd0, 41'h000_2222_0000, 0, 1, 0, 0);
      write_entry(30, 64'h0000_0000_0070_0000, 13'h055, 1, 0, 2'd0, 41'h000_3333_0000, 1, 0, 1, 1);
      write_entry(31, 64'h0000_0000_0071_0000, 13'h000, 1, 0, 2'd0, 41'h000_4444_0000, 0, 0, 0, 1);
      write_entry(40, 64'h0000_0000_0090_0000, 13'h000, 1, 0, 2'd0, 41'h000_5555_0000, 0, 0, 0, 0);
      write_entry(41, 64'h0000_0000_0090_0000, 13'h055, 1, 0, 2'd0, 41'h000_6666_0000, 0, 0, 0, 0);
      write_entry(63, 64'h0000_0000_00A0_0000, 13'h055, 0, 0, 2'd0, 41'h000_7777_0000, 0, 1, 0, 0);

      do_req("R2 R4 8K hit with offset",       64'h0000_1234_5678_BABC, 2'd0, 1, 2'd0, 0, 0);
      do_req("R2 8K next page misses",          64'h0000_1234_5678_C000, 2'd0, 1, 2'd0, 0, 0);
      do_req("R2 R4 64K hit keeps va bits",     64'h0000_0000_4003_E123, 2'd0, 1, 2'd0, 0, 0);
      do_req("R5 R10 secondary 512K write",     64'h0000_0000_8007_F000, 2'd1, 1, 2'd1, 0, 0);
      do_req("R3 R5 primary ctx mismatch miss", 64'h0000_0000_8007_F000, 2'd0, 1, 2'd0, 0, 0);
      do_req("R3 R2 global 4M nucleus read",    64'hFFFF_F800_007F_E000, 2'd0, 1, 2'd2, 0, 0);
      do_req("R6 user on privileged entry",     64'hFFFF_F800_0050_0000, 2'd0, 0, 2'd2, 0, 0);
      do_req("R1 lowest index wins",            64'h0000_0000_0060_0010, 2'd0, 1, 2'd0, 0, 0);
      do_req("R7 R1 write to read-only",        64'h0000_0000_0060_0000, 2'd1, 1, 2'd0, 0, 0);
      do_req("R10 write grant on writable",     64'h0000_1234_5678_A000, 2'd1, 1, 2'd0, 0, 0);
      do_req("R10 read-only grants read only",  64'h0000_0000_4003_0000, 2'd0, 1, 2'd0, 0, 0);
      do_req("R6 R9 nf load to side-effect",    64'h0000_0000_0070_0000, 2'd2, 1, 2'd0, 0, 0);
      do_req("R6 priv and nfo together",        64'h0000_0000_0070_1000, 2'd0, 0, 2'd0, 0, 0);
      do_req("R7 write with access fault",      64'h0000_0000_0070_0000, 2'd1, 0, 2'd0, 0, 0);
      do_req("R6 nucleus nf load side-effect",  64'h0000_0000_0071_0000, 2'd2, 1, 2'd3, 0, 0);
      do_req("R6 nucleus normal read side page",64'h0000_0000_0071_0000, 2'd0, 1, 2'd2, 0, 0);
      do_req("R8 R9 miss keeps status",         64'h0000_0000_00A0_0000, 2'd0, 1, 2'd0, 0, 0);
      do_req("R5 fetch at trap level zero",     64'h0000_0000_0090_0000, 2'd3, 1, 2'd1, 0, 0);
      do_req("R5 fetch at raised trap level",   64'h0000_0000_0090_0000, 2'd3, 1, 2'd1, 0, 1);
      do_req("R9 R5 fetch privilege fault",     64'hFFFF_F800_0040_0000, 2'd3, 0, 2'd0, 0, 1);
      do_req("R11 physical bypass",             64'hFFFF_FFFF_FFFF_F123, 2'd1, 0, 2'd0, 1, 0);
      do_req("R3 invalid entry ignored",        64'h0000_0000_00A0_0000, 2'd1, 1, 2'd2, 0, 0);

      check("R10 used bits after lookups", 256'(used_vec), 256'(m_used));
      write_entry(2, 64'h0000_1234_5678_A000, 13'h055, 1, 0, 2'd0, 41'h0CC_0000_0000, 0, 0, 0, 0);
      check("R10 entry write clears used", 256'(used_vec), 256'(m_used));
      do_req("R12 rewritten entry visible",     64'h0000_1234_5678_A000, 2'd0, 1, 2'd0, 0, 0);
      check("R10 used set again", 256'(used_vec), 256'(m_used));

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) check("R12 results outstanding", 256'(exp_q.size()), 256'(0));
      done = 1'b1;
      summary();
      $finish;
   end

endmodule